// File: doc/BRIEF.md
# Manchester II Frame Encoder

This block turns one serial data word into a Manchester II line frame. A frame is a three-bit-period sync character, then K data bits sent most significant bit first, then one parity bit. K is set by a 5-bit frame-length code and ranges from 2 to 28. The block runs from a fast clock at twelve times the bit rate. An internal divide-by-DIV prescaler makes a half-bit strobe from that clock. The half-bit strobe sets the pace of a shift clock at the bit rate. The divided square wave is also brought out for other logic to use.

The host does not load the word in parallel. The block raises a send-data strobe and then takes one bit from the serial input on each rising shift-clock edge. Each bit it takes appears on the line one bit period later. The frame leaves on two active-low bipolar outputs, one for the positive line state and one for the negative line state. If the host holds enable high, frames follow each other with no gap. An output-enable input can blank the line without stopping the sequencing. An abort input ends a frame at the next half-bit strobe.

Top module: `manchester_frame_enc`

## Requirements
- R1: The half-bit strobe occurs once every DIV clocks, and `div_out` is a square wave with a period of DIV clocks (DIV = 6 by default).
- R2: `shift_clk` changes level on every half-bit strobe. It is low in the first half of each bit period and high in the second half, so its period is 2*DIV clocks.
- R3: A cycle starts when `enable` is high at a falling edge of `shift_clk`, and it lasts K+4 bit periods. `frame_code` gives K+3. Codes 0 to 4 act as code 5, which gives K = 2. The code is latched when the cycle starts.
- R4: `sync_cmd` is sampled at the first rising `shift_clk` edge of the cycle. In bit periods 1 to 3 of the cycle the line carries the sync. A command sync (`sync_cmd` = 1) is three half-bits positive followed by three half-bits negative. A data sync is the opposite.
- R5: `send_data` is high for exactly K bit periods, which are periods 3 to K+2 of the cycle. `serial_in` is sampled at each rising `shift_clk` edge in that window, most significant bit first. Each sampled bit goes on the line in the next bit period. A one is sent as positive then negative, and a zero as negative then positive.
- R6: The parity bit is sent in the bit period after the last data bit, using the same encoding as data. `par_odd` is latched at the start of the cycle. When it is 1, the data and parity together hold an odd number of ones. When it is 0, they hold an even number.
- R7: If `enable` is still high at the end of a cycle, the next cycle starts at once. The parity of one frame is then followed directly by the sync of the next, with no idle half-bit between them. After the parity of a frame that has no successor, the line goes idle.
- R8: While `drive_en` is low, both line outputs are held high (inactive). Sequencing continues underneath, and the rest of the frame comes out correctly once `drive_en` returns high.
- R9: A one-clock pulse on `abort` takes effect at the next half-bit strobe. At that point the frame ends: `send_data` drops, the line goes idle, and nothing more is sent until a new cycle starts.
- R10: While `rst_n` is low at a clock edge, the line outputs are high, and `send_data` and `shift_clk` are low.
- R11: `line_pos_n` and `line_neg_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, DIV times the half-bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Request a frame, sampled at shift-clock falling edges |
| sync_cmd | input | 1 | 1 selects command sync, 0 selects data sync |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| frame_code | input | CODE_W | Frame-length code, equal to K+3 |
| abort | input | 1 | Ends the current frame at the next half-bit strobe |
| drive_en | input | 1 | Low forces both line outputs inactive |
| serial_in | input | 1 | Serial data from the host |
| div_out | output | 1 | Prescaler square wave |
| shift_clk | output | 1 | Bit-rate shift clock |
| send_data | output | 1 | High while the block takes data bits |
| line_pos_n | output | 1 | Active-low drive for the positive line state |
| line_neg_n | output | 1 | Active-low drive for the negative line state |

## Verification
Some properties are checked on every cycle by assertions: the spacing of the prescaler strobe, the shift clock changing level on each strobe, the cycle counter staying within the latched frame length, `send_data` rising only while the shift clock is low, the two line outputs never both being active, and the line staying idle when no cycle or parity is pending. Other behaviour can only be shown by the bench's scenarios. These include the exact half-bit pattern of the sync, the data and the parity for each code, each sync type and each parity sense. They also include the lack of a gap between back-to-back frames, the K-period length of the send window, and recovery after an output blank or an abort.

// File: rtl/mfe_pkg.sv
// Shared types and constants for the Manchester frame encoder.
// Assumes: line levels are encoded as idle / positive / negative.
package mfe_pkg;
    typedef enum logic [1:0] {
        LVL_IDLE = 2'd0,
        LVL_POS  = 2'd1,
        LVL_NEG  = 2'd2
    } lvl_e;

    // Bit periods taken by the sync character.
    localparam int SYNC_BITS = 3;
    // Smallest frame-length code (K = 2); smaller codes clamp to it.
    localparam int MIN_CODE  = 5;
endpackage

// File: rtl/mfe_prescale.sv
// Prescaler: divides the fast clock by DIV to make the half-bit strobe
// and a square wave for other logic.
// Assumes: DIV >= 2; rst_n is synchronous.
module mfe_prescale #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick,
    output logic div_out
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] TOP  = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF = CW'(DIV / 2);

    logic [CW-1:0] cnt;

    // Counts clocks from 0 to DIV-1, then wraps.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt == TOP) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick    = (cnt == TOP);
    assign div_out = (cnt < HALF);

    // Checker: counts the clocks between strobes on its own.
    logic [CW:0] gap;
    logic        seen;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (tick) begin
            gap  <= '0;
            seen <= 1'b1;
        end else begin
            gap  <= gap + 1'b1;
        end
    end

    assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && tick) |-> (gap == (CW+1)'(DIV - 1)));
endmodule

// File: rtl/mfe_seq.sv
// Frame sequencer: makes the shift clock, counts bit periods of a cycle,
// latches sync type, parity sense and frame length, samples serial data
// and builds the parity bit.
// Assumes: tick is a one-clock strobe per half bit; abort is sampled on
// every clock and applied at the next tick.
module mfe_seq #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              enable,
    input  logic              sync_sel,
    input  logic              par_odd,
    input  logic [CODE_W-1:0] cnt_code,
    input  logic              abort,
    input  logic              serial_in,
    output logic              shclk,
    output logic              send_data,
    output logic              busy,
    output logic [CODE_W-1:0] t_o,
    output logic              cmd_o,
    output logic              hold_o,
    output logic              par_act_o,
    output logic              par_val_o
);
    import mfe_pkg::*;

    localparam logic [CODE_W-1:0] MINC   = CODE_W'(MIN_CODE);
    localparam logic [CODE_W-1:0] SEND_1 = CODE_W'(SYNC_BITS);

    logic              phase, cmd_q, odd_q, smp, hold, acc, par_act, par_val;
    logic              abort_pend;
    logic [CODE_W-1:0] t_q, last_q, eff_code;
    logic              at_last, do_abort;

    assign eff_code  = (cnt_code < MINC) ? MINC : cnt_code;
    assign at_last   = busy && (t_q == last_q);
    assign send_data = busy && (t_q >= SEND_1) && (t_q < last_q);
    assign do_abort  = abort_pend | abort;

    // Holds an abort request until the next half-bit strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     abort_pend <= 1'b0;
        else if (tick)  abort_pend <= 1'b0;
        else if (abort) abort_pend <= 1'b1;
    end

    // Moves the cycle forward one half bit on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= 1'b0;
            busy    <= 1'b0;
            t_q     <= '0;
            last_q  <= MINC;
            cmd_q   <= 1'b0;
            odd_q   <= 1'b0;
            smp     <= 1'b0;
            hold    <= 1'b0;
            acc     <= 1'b0;
            par_act <= 1'b0;
            par_val <= 1'b0;
        end else if (tick) begin
            if (do_abort) begin
                phase   <= 1'b0;
                busy    <= 1'b0;
                t_q     <= '0;
                smp     <= 1'b0;
                hold    <= 1'b0;
                acc     <= 1'b0;
                par_act <= 1'b0;
            end else if (!phase) begin
                // Mid bit, rising shift-clock edge: sample the inputs.
                phase <= 1'b1;
                if (busy && t_q == '0) cmd_q <= sync_sel;
                if (send_data) begin
                    smp <= serial_in;
                    acc <= acc ^ serial_in;
                end
            end else begin
                // Bit boundary, falling shift-clock edge.
                phase   <= 1'b0;
                hold    <= smp;
                par_act <= at_last;
                if (at_last) begin
                    par_val <= acc ^ odd_q;
                    acc     <= 1'b0;
                end
                if (enable && (!busy || at_last)) begin
                    busy   <= 1'b1;
                    t_q    <= '0;
                    last_q <= eff_code;
                    odd_q  <= par_odd;
                end else if (at_last) begin
                    busy <= 1'b0;
                    t_q  <= '0;
                end else if (busy) begin
                    t_q <= t_q + 1'b1;
                end
            end
        end
    end

    assign shclk     = phase;
    assign t_o       = t_q;
    assign cmd_o     = cmd_q;
    assign hold_o    = hold;
    assign par_act_o = par_act;
    assign par_val_o = par_val;

    assert_shclk_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !do_abort) |=> (shclk != $past(shclk)));
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (t_q <= last_q && last_q >= MINC));
    assert_send_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(send_data) |-> !shclk);
endmodule

// File: rtl/mfe_line.sv
// Line former: works out the line level for the current half bit from
// the sequencer state and drives the two active-low bipolar outputs.
// Assumes: hold holds the bit sampled in the previous bit period.
module mfe_line #(
    parameter int CODE_W = 5
) (
    input  logic              busy,
    input  logic [CODE_W-1:0] t,
    input  logic              phase,
    input  logic              cmd,
    input  logic              hold,
    input  logic              par_act,
    input  logic              par_val,
    input  logic              drive_en,
    output logic              one_n,
    output logic              zero_n
);
    import mfe_pkg::*;

    localparam logic [CODE_W-1:0] DATA_1 = CODE_W'(SYNC_BITS + 1);

    lvl_e       lvl;
    logic [1:0] tm1;
    logic [2:0] sidx;

    assign tm1  = t[1:0] - 2'd1;
    assign sidx = {tm1, phase};

    // Chooses the level for this half bit: parity, sync, data or idle.
    always_comb begin
        lvl = LVL_IDLE;
        if (par_act) begin
            lvl = (par_val ^ phase) ? LVL_POS : LVL_NEG;
        end else if (busy && t != '0 && t < DATA_1) begin
            lvl = ((sidx < 3'd3) == cmd) ? LVL_POS : LVL_NEG;
        end else if (busy && t >= DATA_1) begin
            lvl = (hold ^ phase) ? LVL_POS : LVL_NEG;
        end
    end

    assign one_n  = !(drive_en && lvl == LVL_POS);
    assign zero_n = !(drive_en && lvl == LVL_NEG);
endmodule

// File: rtl/manchester_frame_enc.sv
// Manchester II frame encoder top: prescaler, frame sequencer and line
// former.
// Assumes: clk runs at DIV times the half-bit rate; rst_n is
// synchronous and active low.
module manchester_frame_enc #(
    parameter int DIV    = 6,
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              sync_cmd,
    input  logic              par_odd,
    input  logic [CODE_W-1:0] frame_code,
    input  logic              abort,
    input  logic              drive_en,
    input  logic              serial_in,
    output logic              div_out,
    output logic              shift_clk,
    output logic              send_data,
    output logic              line_pos_n,
    output logic              line_neg_n
);
    logic              tick, busy, cmd, hold, par_act, par_val;
    logic [CODE_W-1:0] t;

    mfe_prescale #(.DIV(DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick), .div_out(div_out)
    );

    mfe_seq #(.CODE_W(CODE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable),
        .sync_sel(sync_cmd), .par_odd(par_odd), .cnt_code(frame_code),
        .abort(abort), .serial_in(serial_in), .shclk(shift_clk),
        .send_data(send_data), .busy(busy), .t_o(t), .cmd_o(cmd),
        .hold_o(hold), .par_act_o(par_act), .par_val_o(par_val)
    );

    mfe_line #(.CODE_W(CODE_W)) u_line (
        .busy(busy), .t(t), .phase(shift_clk), .cmd(cmd), .hold(hold),
        .par_act(par_act), .par_val(par_val), .drive_en(drive_en),
        .one_n(line_pos_n), .zero_n(line_neg_n)
    );

    assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (line_pos_n || line_neg_n));
    assert_idle_when_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !par_act) |-> (line_pos_n && line_neg_n));
endmodule

// File: tb/manchester_frame_enc_test.sv
module manchester_frame_enc_test;
    localparam int DIV = 6;
    localparam int CW  = 5;
    localparam logic [1:0] POS = 2'b01, NEG = 2'b10, IDL = 2'b11;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, enable = 1'b0, sync_cmd = 1'b0, par_odd = 1'b0;
    logic abort = 1'b0, drive_en = 1'b1, serial_in = 1'b0;
    logic [CW-1:0] frame_code = 5'd5;
    logic div_out, shift_clk, send_data, line_pos_n, line_neg_n;

    manchester_frame_enc #(.DIV(DIV), .CODE_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sync_cmd(sync_cmd),
        .par_odd(par_odd), .frame_code(frame_code), .abort(abort),
        .drive_en(drive_en), .serial_in(serial_in), .div_out(div_out),
        .shift_clk(shift_clk), .send_data(send_data),
        .line_pos_n(line_pos_n), .line_neg_n(line_neg_n)
    );

    int total = 0, bad = 0;
    longint cyc = 0;
    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Scoreboard queues: expected half-bit line codes, words for the feeder.
    logic [1:0]  expq[$];
    logic [31:0] wq[$];
    int          kq[$];

    // Monitor: compares each half bit against the expected queue.
    logic       prev_sh = 1'b0;
    bit         armed = 1'b0;
    logic [1:0] cur, e;
    always @(negedge clk) begin
        if (!rst_n) begin
            armed = 1'b0;
        end else if (shift_clk != prev_sh) begin
            cur = {line_pos_n, line_neg_n};
            if (cur == 2'b00) check(1'b0, "R11", "both line outputs active", cur, IDL);
            if (!armed && expq.size() != 0 && cur != IDL) armed = 1'b1;
            if (armed) begin
                if (expq.size() != 0) begin
                    e = expq.pop_front();
                    if (!drive_en) check(cur == IDL, "R8", "blanked half bit", cur, IDL);
                    else           check(cur == e, "R4 R5 R6", "line half bit", cur, e);
                end else begin
                    check(cur == IDL, "R7", "idle after last parity", cur, IDL);
                    armed = 1'b0;
                end
            end
        end
        prev_sh = shift_clk;
    end

    // Feeder: presents the next word bit at each shift-clock fall in the window.
    logic        prev_f = 1'b0;
    int          fi = 0, fk = 2;
    logic [31:0] fw = '0;
    always @(negedge clk) begin
        if (prev_f && !shift_clk && send_data) begin
            if (fi == 0) begin
                fw = wq.pop_front();
                fk = kq.pop_front();
            end
            serial_in <= fw[fk-1-fi];
            fi++;
            if (fi == fk) fi = 0;
        end
        prev_f = shift_clk;
    end

    // Length of the last send_data window, in clocks.
    int sd_run = 0, sd_last = 0;
    always @(negedge clk) begin
        if (send_data) sd_run++;
        else if (sd_run != 0) begin
            sd_last = sd_run;
            sd_run  = 0;
        end
    end

    function automatic int k_of(input logic [4:0] code);
        return (code < 5) ? 2 : int'(code) - 3;
    endfunction

    // Driver: queues the expected frame and the word, then starts it.
    task automatic run_frame(input logic [4:0] code, input logic [31:0] word,
                             input bit cmd, input bit odd, input bit keep,
                             output longint rise_at);
        int   k;
        logic p;
        k = k_of(code);
        p = odd;
        for (int i = 0; i < 6; i++)
            expq.push_back((i < 3) ? (cmd ? POS : NEG) : (cmd ? NEG : POS));
        for (int j = k - 1; j >= 0; j--) begin
            expq.push_back(word[j] ? POS : NEG);
            expq.push_back(word[j] ? NEG : POS);
            p = p ^ word[j];
        end
        expq.push_back(p ? POS : NEG);
        expq.push_back(p ? NEG : POS);
        wq.push_back(word);
        kq.push_back(k);
        @(posedge clk); #1;
        sync_cmd = cmd; par_odd = odd; frame_code = code; enable = 1'b1;
        while (send_data) @(negedge clk);
        while (!send_data) @(negedge clk);
        rise_at = cyc;
        @(posedge clk); #1;
        if (!keep) enable = 1'b0;
    endtask

    task automatic drain();
        int n;
        n = 0;
        while ((expq.size() != 0 || armed) && n < 6000) begin
            @(negedge clk);
            n++;
        end
        repeat (30) @(negedge clk);
    endtask

    task automatic period_of(input bit which, output longint p);
        logic   pv, v;
        longint t0;
        int     seen;
        seen = 0; t0 = 0; p = 0;
        pv = which ? shift_clk : div_out;
        while (seen < 2) begin
            @(negedge clk);
            v = which ? shift_clk : div_out;
            if (v && !pv) begin
                if (seen == 1) p = cyc - t0;
                t0 = cyc;
                seen++;
            end
            pv = v;
        end
    endtask

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        longint r1, r2, p;
        int     hits;

        repeat (3) @(negedge clk);
        check(line_pos_n && line_neg_n, "R10", "line idle in reset", {line_pos_n, line_neg_n}, IDL);
        check(!send_data, "R10", "send_data low in reset", send_data, 0);
        check(!shift_clk, "R10", "shift_clk low in reset", shift_clk, 0);
        @(posedge clk); #1 rst_n = 1'b1;

        period_of(1'b0, p);
        check(p == DIV, "R1", "div_out period", p, DIV);
        period_of(1'b1, p);
        check(p == 2 * DIV, "R2", "shift_clk period", p, 2 * DIV);

        // Command sync, odd parity, K = 17.
        run_frame(5'd20, 32'h1A5B3, 1'b1, 1'b1, 1'b0, r1);
        drain();
        check(sd_last == 17 * 2 * DIV, "R5", "send window K=17", sd_last, 17 * 2 * DIV);

        // Data sync, even parity, K = 2.
        run_frame(5'd5, 32'h1, 1'b0, 1'b0, 1'b0, r1);
        drain();

        // Code below 5 acts as K = 2.
        run_frame(5'd3, 32'h2, 1'b1, 1'b0, 1'b0, r1);
        drain();
        check(sd_last == 2 * 2 * DIV, "R3", "code 3 gives K=2", sd_last, 2 * 2 * DIV);

        // Longest frame, K = 28.
        run_frame(5'd31, 32'h0A5C3F0E, 1'b0, 1'b1, 1'b0, r1);
        drain();
        check(sd_last == 28 * 2 * DIV, "R5", "send window K=28", sd_last, 28 * 2 * DIV);

        // Back-to-back: K = 5 then K = 9, with different sync and parity.
        run_frame(5'd8, 32'h16, 1'b1, 1'b0, 1'b1, r1);
        run_frame(5'd12, 32'h1C9, 1'b0, 1'b1, 1'b0, r2);
        check(r2 - r1 == (5 + 4) * 2 * DIV, "R3", "cycle length K+4 (R7 gapless)",
              r2 - r1, (5 + 4) * 2 * DIV);
        drain();
        check(sd_last == 9 * 2 * DIV, "R5", "second send window", sd_last, 9 * 2 * DIV);

        // Blank the line partway through a frame.
        run_frame(5'd21, 32'h2B4D1, 1'b1, 1'b0, 1'b0, r1);
        @(posedge clk); #1 drive_en = 1'b0;
        repeat (40) @(negedge clk);
        check(line_pos_n && line_neg_n, "R8", "outputs held high", {line_pos_n, line_neg_n}, IDL);
        @(posedge clk); #1 drive_en = 1'b1;
        drain();

        // Abort during the sync.
        @(posedge clk); #1;
        frame_code = 5'd10; sync_cmd = 1'b1; enable = 1'b1;
        hits = 0;
        while (line_pos_n && line_neg_n && hits < 500) begin
            @(negedge clk);
            hits++;
        end
        @(posedge clk); #1 abort = 1'b1;
        @(posedge clk); #1 abort = 1'b0; enable = 1'b0;
        repeat (8) @(negedge clk);
        check(line_pos_n && line_neg_n, "R9", "line idle after abort", {line_pos_n, line_neg_n}, IDL);
        hits = 0;
        repeat (100) begin
            @(negedge clk);
            if (send_data || !line_pos_n || !line_neg_n) hits++;
        end
        check(hits == 0, "R9", "nothing sent after abort", hits, 0);

        // Recovery frame after the abort.
        run_frame(5'd6, 32'h5, 1'b0, 1'b1, 1'b0, r1);
        drain();
        check(sd_last == 3 * 2 * DIV, "R9", "frame after abort", sd_last, 3 * 2 * DIV);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule